// File: doc/BRIEF.md
# Word FIFO to Byte-Stream Data Engine

This block sits between a host side that works in 32-bit words and a card side that moves one byte at a time. A small circular FIFO of words holds data in between. In the receive direction the engine takes bytes from the card whenever the card signals ready and there is room, packs them into words least significant byte first, and pushes each word into the FIFO for the host to pop. In the transmit direction the host pushes words and the engine unpacks them, lowest byte first, into a byte stream toward the card.

A transfer is set up by writing a byte length, then writing the control inputs with the enable bit set. This loads a byte counter that counts down once per byte moved. When the counter hits zero the engine raises sticky end-of-data and end-of-block flags. Once the FIFO has also drained, the engine turns itself off. While it runs, the engine reports fill-level flags for the active direction only, together with the number of words still to move.

Top module: `wbx_engine`

## Requirements
- R1: After reset the engine is disabled, the byte counter and FIFO fill level are zero, and all status flags (active, level and end flags) are low.
- R2: A control write with the enable bit set loads the byte counter from the last written length and clears the end-of-data and end-of-block flags. `word_cnt` always equals (byte counter + 3) >> 2.
- R3: In the receive direction (direction bit = 1), the k-th card byte of a transfer is placed in bits [8*(k mod 4)+7 : 8*(k mod 4)] of FIFO word k/4. Words leave the FIFO in the order they were pushed.
- R4: If the counter reaches zero with 1 to 3 bytes collected, that partial word is pushed, with its unused upper bytes set to zero.
- R5: A receive transfer takes no card byte (`card_rd_take` low, counter unchanged) while the FIFO holds 16 words or `card_ready` is low. It resumes in the cycle after a host pop frees space.
- R6: In the transmit direction (direction bit = 0), a word is popped only when no bytes of the previous word remain, and its bytes are sent lowest byte first, one per cycle with `card_wr_valid` high.
- R7: A transmit transfer sends nothing while the FIFO is empty and no bytes of a popped word are left.
- R8: The byte counter falls by exactly one for each byte moved in either direction.
- R9: While enabled with a zero counter, end-of-data and end-of-block are set on the next clock. They stay set until the next enabling control write.
- R10: While enabled with a zero counter and an empty FIFO, the engine disables itself on the next clock. In that same cycle every active and level flag goes low.
- R11: While enabled, the level flags are: empty at fill 0, data-available above 0, full at 16, half-empty at 8 or fewer, half-full at 8 or more. Only the transmit set is driven when the direction is 0, and only the receive set when it is 1.
- R12: A push into a full FIFO, a host push in the receive direction and a host pop in the transmit direction are all ignored. A host pop from an empty FIFO returns zero and leaves the fill level at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Write strobe for the length value |
| len_val | input | 16 | Transfer length in bytes |
| ctrl_wr | input | 1 | Write strobe for the control inputs |
| ctrl_enable | input | 1 | Enable bit; when set with ctrl_wr it loads the counter |
| ctrl_dir | input | 1 | Direction: 1 = card to FIFO, 0 = FIFO to card |
| host_push | input | 1 | Host word push request |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host word pop request |
| host_rdata | output | 32 | Popped word, zero if the pop is not accepted |
| card_ready | input | 1 | Card has a byte available (receive) |
| card_rd_byte | input | 8 | Byte offered by the card |
| card_rd_take | output | 1 | Engine consumes card_rd_byte this cycle |
| card_wr_valid | output | 1 | Engine sends card_wr_byte this cycle |
| card_wr_byte | output | 8 | Byte sent to the card |
| engine_en | output | 1 | Engine enabled |
| byte_cnt | output | 16 | Remaining byte count |
| word_cnt | output | 15 | Remaining word count |
| fill_level | output | 5 | Words held in the FIFO |
| data_end | output | 1 | Sticky end-of-data flag |
| block_end | output | 1 | Sticky end-of-block flag |
| tx_active | output | 1 | Transmit active |
| tx_half_empty | output | 1 | Transmit FIFO at half or below |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_avail | output | 1 | Transmit FIFO has data |
| rx_active | output | 1 | Receive active |
| rx_half_full | output | 1 | Receive FIFO at half or above |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_avail | output | 1 | Receive FIFO has data |

## Verification
The counter and end-flag properties are written only for cycles without a control write, because a control write replaces the counter and the enable state. The last-byte property assumes no host pop in that same cycle. The stimulus pushes host words in the transmit direction only up to what the loaded length consumes, except in the full-FIFO test, which is ended by a reset. `card_rd_byte` is driven stable from mid-cycle through the sampling edge. Control and length writes are only issued between transfers or to start a new one.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

   typedef enum logic {
      WBX_TX = 1'b0,
      WBX_RX = 1'b1
   } wbx_dir_e;

   typedef struct packed {
      logic active;
      logic half;
      logic full;
      logic empty;
      logic avail;
   } wbx_side_t;

endpackage

// File: rtl/wbx_fifo.sv
module wbx_fifo #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int FILL_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [WORD_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [WORD_W-1:0] head_o,
   output logic [FILL_W-1:0] fill_o
);

   localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbx_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr;
   logic [FILL_W-1:0] fill;
   logic [PTR_W-1:0]  wr_idx;
   logic              push_ok, pop_ok;

   assign push_ok = push_i && (fill != FULL_LVL);
   assign pop_ok  = pop_i && (fill != '0);
   assign wr_idx  = rd_ptr + fill[PTR_W-1:0];
   assign head_o  = mem[rd_ptr];
   assign fill_o  = fill;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_idx] <= push_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + FILL_W'(push_ok) - FILL_W'(pop_ok);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_LVL); // R12
   AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && fill == FULL_LVL) |=> (fill == FULL_LVL && $stable(rd_ptr))); // R12
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && fill == '0) |=> (fill == '0 && $stable(rd_ptr))); // R12

endmodule

// File: rtl/wbx_rx_pack.sv
module wbx_rx_pack #(
   parameter int WORD_W = 32,
   localparam int BYTES = WORD_W / 8,
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              take_i,
   input  logic              last_i,
   input  logic [7:0]        byte_i,
   output logic              push_o,
   output logic [WORD_W-1:0] word_o
);

   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] acc;

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign word_o[8*i +: 8] = (idx == IDX_W'(i)) ? byte_i : acc[8*i +: 8];
   end

   assign push_o = take_i && ((idx == IDX_W'(BYTES - 1)) || last_i);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         idx <= '0;
         acc <= '0;
      end else if (take_i) begin
         if (push_o) begin
            idx <= '0;
            acc <= '0;
         end else begin
            idx <= idx + 1'b1;
            acc <= word_o;
         end
      end
   end

endmodule

// File: rtl/wbx_tx_unpack.sv
module wbx_tx_unpack #(
   parameter int WORD_W = 32,
   localparam int BYTES = WORD_W / 8,
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              move_i,
   input  logic [WORD_W-1:0] head_i,
   output logic              pop_o,
   output logic              mid_o,
   output logic [7:0]        byte_o
);

   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] hold;

   assign mid_o  = (idx != '0);
   assign pop_o  = move_i && !mid_o;
   assign byte_o = mid_o ? hold[8*idx +: 8] : head_i[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         idx  <= '0;
         hold <= '0;
      end else if (move_i) begin
         if (!mid_o) hold <= head_i;
         idx <= idx + 1'b1;
      end
   end

endmodule

// File: rtl/wbx_flags.sv
module wbx_flags
   import wbx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int FILL_W = $clog2(DEPTH) + 1
) (
   input  logic              en_i,
   input  wbx_dir_e          dir_i,
   input  logic [FILL_W-1:0] fill_i,
   output wbx_side_t         tx_o,
   output wbx_side_t         rx_o
);

   localparam logic [FILL_W-1:0] HALF = FILL_W'(DEPTH / 2);
   localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

   wbx_side_t tx_lvl, rx_lvl;

   always_comb begin
      tx_lvl.active = 1'b1;
      tx_lvl.half   = (fill_i <= HALF);
      tx_lvl.full   = (fill_i == FULL);
      tx_lvl.empty  = (fill_i == '0);
      tx_lvl.avail  = (fill_i != '0);
      rx_lvl        = tx_lvl;
      rx_lvl.half   = (fill_i >= HALF);
   end

   assign tx_o = (en_i && dir_i == WBX_TX) ? tx_lvl : '0;
   assign rx_o = (en_i && dir_i == WBX_RX) ? rx_lvl : '0;

endmodule

// File: rtl/wbx_engine.sv
module wbx_engine
   import wbx_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   parameter int LEN_W  = 16,
   localparam int FILL_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_wr,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              ctrl_wr,
   input  logic              ctrl_enable,
   input  logic              ctrl_dir,
   input  logic              host_push,
   input  logic [WORD_W-1:0] host_wdata,
   input  logic              host_pop,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              card_ready,
   input  logic [7:0]        card_rd_byte,
   output logic              card_rd_take,
   output logic              card_wr_valid,
   output logic [7:0]        card_wr_byte,
   output logic              engine_en,
   output logic [LEN_W-1:0]  byte_cnt,
   output logic [LEN_W-2:0]  word_cnt,
   output logic [FILL_W-1:0] fill_level,
   output logic              data_end,
   output logic              block_end,
   output logic              tx_active,
   output logic              tx_half_empty,
   output logic              tx_full,
   output logic              tx_empty,
   output logic              tx_avail,
   output logic              rx_active,
   output logic              rx_half_full,
   output logic              rx_full,
   output logic              rx_empty,
   output logic              rx_avail
);

   localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);

   if (WORD_W < 16 || (WORD_W % 8) != 0 || ((WORD_W / 8) & (WORD_W / 8 - 1)) != 0) begin : g_bad_word
      $error("wbx_engine: WORD_W must be a power-of-two count of bytes, at least 2");
   end
   if (LEN_W < 3) begin : g_bad_len
      $error("wbx_engine: LEN_W must be at least 3");
   end

   logic [LEN_W-1:0]  len_q, cnt;
   logic              en, done;
   wbx_dir_e          dir;
   logic              load, cnt_zero;
   logic              rx_take, tx_move;
   logic              pk_push, up_pop, up_mid;
   logic [WORD_W-1:0] pk_word, head;
   logic [FILL_W-1:0] fill;
   logic              fifo_push, fifo_pop, host_push_ok, host_pop_ok;
   logic [WORD_W-1:0] fifo_wdata;
   logic [LEN_W:0]    cnt_plus;
   wbx_side_t         tx_s, rx_s;

   assign load     = ctrl_wr && ctrl_enable;
   assign cnt_zero = (cnt == '0);

   assign rx_take = en && dir == WBX_RX && !cnt_zero && card_ready && fill != FULL_LVL;
   assign tx_move = en && dir == WBX_TX && !cnt_zero && (up_mid || fill != '0);

   assign host_push_ok = host_push && en && dir == WBX_TX && !cnt_zero;
   assign host_pop_ok  = host_pop && dir == WBX_RX && fill != '0;

   assign fifo_push  = (dir == WBX_RX) ? pk_push : host_push_ok;
   assign fifo_wdata = (dir == WBX_RX) ? pk_word : host_wdata;
   assign fifo_pop   = (dir == WBX_RX) ? host_pop_ok : up_pop;

   wbx_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(fifo_push), .push_data_i(fifo_wdata),
      .pop_i(fifo_pop), .head_o(head), .fill_o(fill)
   );

   wbx_rx_pack #(.WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr_i(load),
      .take_i(rx_take), .last_i(cnt == LEN_W'(1)), .byte_i(card_rd_byte),
      .push_o(pk_push), .word_o(pk_word)
   );

   wbx_tx_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .clr_i(load),
      .move_i(tx_move), .head_i(head),
      .pop_o(up_pop), .mid_o(up_mid), .byte_o(card_wr_byte)
   );

   wbx_flags #(.DEPTH(DEPTH)) u_flags (
      .en_i(en), .dir_i(dir), .fill_i(fill), .tx_o(tx_s), .rx_o(rx_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
         cnt   <= '0;
         en    <= 1'b0;
         dir   <= WBX_TX;
         done  <= 1'b0;
      end else begin
         if (len_wr) len_q <= len_val;
         if (ctrl_wr) begin
            en  <= ctrl_enable;
            dir <= wbx_dir_e'(ctrl_dir);
            if (ctrl_enable) begin
               cnt  <= len_q;
               done <= 1'b0;
            end
         end else begin
            if (rx_take || tx_move) cnt <= cnt - 1'b1;
            if (en && cnt_zero) done <= 1'b1;
            if (en && cnt_zero && fill == '0) en <= 1'b0;
         end
      end
   end

   assign cnt_plus = {1'b0, cnt} + (LEN_W + 1)'(3);

   assign host_rdata    = host_pop_ok ? head : '0;
   assign card_rd_take  = rx_take;
   assign card_wr_valid = tx_move;
   assign engine_en     = en;
   assign byte_cnt      = cnt;
   assign word_cnt      = cnt_plus[LEN_W:2];
   assign fill_level    = fill;
   assign data_end      = done;
   assign block_end     = done;
   assign tx_active     = tx_s.active;
   assign tx_half_empty = tx_s.half;
   assign tx_full       = tx_s.full;
   assign tx_empty      = tx_s.empty;
   assign tx_avail      = tx_s.avail;
   assign rx_active     = rx_s.active;
   assign rx_half_full  = rx_s.half;
   assign rx_full       = rx_s.full;
   assign rx_empty      = rx_s.empty;
   assign rx_avail      = rx_s.avail;

   AST_LOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (byte_cnt == $past(len_q) && !data_end)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_wr && (card_rd_take || card_wr_valid)) |=> (byte_cnt == $past(byte_cnt) - 1'b1)); // R8
   AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      card_rd_take |-> (fill != FULL_LVL && card_ready)); // R5
   AST_TX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      card_wr_valid |-> (fill != '0 || up_mid)); // R7
   AST_LAST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rd_take && byte_cnt == LEN_W'(1) && !host_pop) |=> (fill == $past(fill) + 1'b1)); // R4
   AST_END_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_en && byte_cnt == '0 && !ctrl_wr) |=> (data_end && block_end)); // R9
   AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_en && byte_cnt == '0 && fill == '0 && !ctrl_wr) |=> !engine_en); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !engine_en |-> !(tx_active || tx_half_empty || tx_full || tx_empty || tx_avail ||
                       rx_active || rx_half_full || rx_full || rx_empty || rx_avail)); // R10
   AST_DIR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_active |-> !tx_active) and (rx_avail |-> !tx_avail)); // R11

endmodule

// File: tb/wbx_engine_tb.sv
module wbx_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        len_wr, ctrl_wr, ctrl_enable, ctrl_dir;
   logic [15:0] len_val;
   logic        host_push, host_pop;
   logic [31:0] host_wdata, host_rdata;
   logic        card_ready, card_rd_take, card_wr_valid;
   logic [7:0]  card_rd_byte, card_wr_byte;
   logic        engine_en, data_end, block_end;
   logic [15:0] byte_cnt;
   logic [14:0] word_cnt;
   logic [4:0]  fill_level;
   logic        tx_active, tx_half_empty, tx_full, tx_empty, tx_avail;
   logic        rx_active, rx_half_full, rx_full, rx_empty, rx_avail;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   wbx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
      .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable), .ctrl_dir(ctrl_dir),
      .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
      .host_rdata(host_rdata), .card_ready(card_ready), .card_rd_byte(card_rd_byte),
      .card_rd_take(card_rd_take), .card_wr_valid(card_wr_valid), .card_wr_byte(card_wr_byte),
      .engine_en(engine_en), .byte_cnt(byte_cnt), .word_cnt(word_cnt), .fill_level(fill_level),
      .data_end(data_end), .block_end(block_end),
      .tx_active(tx_active), .tx_half_empty(tx_half_empty), .tx_full(tx_full),
      .tx_empty(tx_empty), .tx_avail(tx_avail),
      .rx_active(rx_active), .rx_half_full(rx_half_full), .rx_full(rx_full),
      .rx_empty(rx_empty), .rx_avail(rx_avail)
   );

   // len[55:40], expected word count [39:32], expected last word [31:0]
   localparam logic [55:0] RX_VEC [5] = '{
      {16'd4,  8'd1, 32'h13121110},
      {16'd5,  8'd2, 32'h00000014},
      {16'd7,  8'd2, 32'h00161514},
      {16'd1,  8'd1, 32'h00000010},
      {16'd10, 8'd3, 32'h00001918}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; len_wr = 0; ctrl_wr = 0; ctrl_enable = 0; ctrl_dir = 0;
      len_val = '0; host_push = 0; host_pop = 0; host_wdata = '0;
      card_ready = 0; card_rd_byte = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic load(input logic [15:0] len, input logic dir);
      len_wr = 1; len_val = len;
      tick();
      len_wr = 0; ctrl_wr = 1; ctrl_enable = 1; ctrl_dir = dir;
      tick();
      ctrl_wr = 0;
   endtask

   function automatic logic [31:0] exp_word(input int w, input int len);
      logic [31:0] r = '0;
      for (int b = 0; b < 4; b++)
         if (4 * w + b < len) r[8*b +: 8] = 8'(8'h10 + 4 * w + b);
      return r;
   endfunction

   function automatic logic [9:0] all_flags();
      return {tx_active, tx_half_empty, tx_full, tx_empty, tx_avail,
              rx_active, rx_half_full, rx_full, rx_empty, rx_avail};
   endfunction

   task automatic rx_run(input int len, input int nwords, input logic [31:0] last_w);
      int k = 0;
      int guard = 0;
      logic t;
      load(16'(len), 1'b1);
      #1;
      chk("R2 load count", 32'(byte_cnt), 32'(len));
      chk("R2 word count", 32'(word_cnt), 32'((len + 3) / 4));
      card_ready = 1;
      while (k < len && guard < 1000) begin
         card_rd_byte = 8'(8'h10 + k);
         #1;
         t = card_rd_take;
         tick();
         if (t) k++;
         guard++;
      end
      card_ready = 0;
      tick();
      #1;
      chk("R9 data end", 32'(data_end), 32'd1);
      chk("R9 block end", 32'(block_end), 32'd1);
      chk("R4 words pushed", 32'(fill_level), 32'(nwords));
      chk("R10 still on while FIFO holds data", 32'(engine_en), 32'd1);
      chk("R11 rx avail / tx hidden", {30'd0, rx_avail, tx_avail}, 32'd2);
      for (int w = 0; w < nwords; w++) begin
         host_pop = 1;
         #1;
         chk("R3 packed word", host_rdata, exp_word(w, len));
         if (w == nwords - 1) chk("R4 last word", host_rdata, last_w);
         tick();
         host_pop = 0;
      end
      tick();
      #1;
      chk("R10 auto disable", 32'(engine_en), 32'd0);
      chk("R10 flags clear", 32'(all_flags()), 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] acc_w [40];
      logic [7:0]  got [160];
      int n_acc, n_got, bad;
      bit saw_full, seen7, seen8, seen8t, seen9t;
      int k, guard;
      logic t, f;

      do_reset();
      #1;
      chk("R1 enable", 32'(engine_en), 32'd0);
      chk("R1 count", 32'(byte_cnt), 32'd0);
      chk("R1 fill", 32'(fill_level), 32'd0);
      chk("R1 flags", {21'd0, all_flags(), data_end}, 32'd0);

      // table-driven receive transfers
      for (int v = 0; v < 5; v++)
         rx_run(int'(RX_VEC[v][55:40]), int'(RX_VEC[v][39:32]), RX_VEC[v][31:0]);

      // empty pop and wrong-direction push
      ctrl_wr = 1; ctrl_enable = 0; ctrl_dir = 1;
      tick();
      ctrl_wr = 0;
      host_pop = 1;
      #1;
      chk("R12 empty pop data", host_rdata, 32'd0);
      tick();
      host_pop = 0;
      host_push = 1; host_wdata = 32'hDEADBEEF;
      tick();
      host_push = 0;
      #1;
      chk("R12 fill stays zero", 32'(fill_level), 32'd0);

      // zero length
      load(16'd0, 1'b0);
      tick();
      #1;
      chk("R10 zero length off", 32'(engine_en), 32'd0);
      chk("R9 zero length end", 32'(data_end), 32'd1);

      // reload clears end flags, card not ready stalls
      load(16'd8, 1'b1);
      card_rd_byte = 8'h55;
      #1;
      chk("R2 end cleared", {30'd0, data_end, block_end}, 32'd0);
      for (int i = 0; i < 3; i++) begin
         #1;
         chk("R5 no take when not ready", 32'(card_rd_take), 32'd0);
         tick();
      end
      chk("R5 count held", 32'(byte_cnt), 32'd8);

      // receive into full FIFO
      do_reset();
      load(16'd80, 1'b1);
      card_ready = 1;
      k = 0; guard = 0; seen7 = 0; seen8 = 0;
      while (guard < 200) begin
         card_rd_byte = 8'(8'h10 + k);
         #1;
         if (fill_level == 5'd7 && !seen7) begin
            chk("R11 rx half-full below 8", 32'(rx_half_full), 32'd0);
            seen7 = 1;
         end
         if (fill_level == 5'd8 && !seen8) begin
            chk("R11 rx half-full at 8", 32'(rx_half_full), 32'd1);
            seen8 = 1;
         end
         if (fill_level == 5'd16) break;
         t = card_rd_take;
         tick();
         if (t) k++;
         guard++;
      end
      chk("R11 rx full", {29'd0, rx_full, rx_empty, tx_full}, 32'd4);
      chk("R5 no take when full", 32'(card_rd_take), 32'd0);
      chk("R8 count after 64 bytes", 32'(byte_cnt), 32'd16);
      chk("R2 word count", 32'(word_cnt), 32'd4);
      host_pop = 1;
      #1;
      chk("R3 first word", host_rdata, 32'h13121110);
      tick();
      host_pop = 0;
      #1;
      chk("R5 resumes after pop", 32'(card_rd_take), 32'd1);

      // transmit: two words, six bytes
      do_reset();
      load(16'd6, 1'b0);
      #1;
      chk("R7 stall on empty", 32'(card_wr_valid), 32'd0);
      chk("R11 tx flags empty", {27'd0, tx_active, tx_half_empty, tx_full, tx_empty, rx_active}, 32'b11010);
      n_got = 0;
      host_push = 1; host_wdata = 32'hA3A2A1A0;
      tick();
      host_wdata = 32'hB3B2B1B0;
      #1;
      if (card_wr_valid) begin got[n_got] = card_wr_byte; n_got++; end
      tick();
      host_push = 0;
      for (int i = 0; i < 10; i++) begin
         #1;
         if (card_wr_valid && n_got < 160) begin got[n_got] = card_wr_byte; n_got++; end
         tick();
      end
      chk("R8 bytes sent", 32'(n_got), 32'd6);
      chk("R6 byte order", {got[0], got[1], got[2], got[3]}, 32'hA0A1A2A3);
      chk("R6 second word", {16'd0, got[4], got[5]}, 32'h0000B0B1);
      chk("R9 tx end", 32'(data_end), 32'd1);
      chk("R10 tx off", 32'(engine_en), 32'd0);

      // transmit into full FIFO, pushes beyond full are dropped
      do_reset();
      load(16'd400, 1'b0);
      n_acc = 0; n_got = 0; saw_full = 0; seen8t = 0; seen9t = 0;
      for (int j = 0; j < 60 && !saw_full; j++) begin
         host_push = 1;
         host_wdata = 32'(j) * 32'h01010101 + 32'h40302010;
         #1;
         f = tx_full;
         if (fill_level == 5'd8 && !seen8t) begin
            chk("R11 tx half-empty at 8", 32'(tx_half_empty), 32'd1);
            seen8t = 1;
         end
         if (fill_level == 5'd9 && !seen9t) begin
            chk("R11 tx half-empty above 8", 32'(tx_half_empty), 32'd0);
            seen9t = 1;
         end
         if (card_wr_valid) begin got[n_got] = card_wr_byte; n_got++; end
         if (f) begin
            saw_full = 1;
            chk("R11 tx full level", {27'd0, fill_level}, 32'd16);
            chk("R11 tx full flags", {29'd0, tx_half_empty, tx_avail, rx_full}, 32'b010);
         end
         tick();
         if (!f) begin acc_w[n_acc] = host_wdata; n_acc++; end
      end
      host_push = 0;
      chk("R11 tx full seen", 32'(saw_full), 32'd1);
      for (int i = 0; i < 120; i++) begin
         #1;
         if (card_wr_valid && n_got < 160) begin got[n_got] = card_wr_byte; n_got++; end
         tick();
      end
      chk("R12 only accepted words sent", 32'(n_got), 32'(4 * n_acc));
      bad = 0;
      for (int i = 0; i < n_got && i < 4 * n_acc; i++)
         if (got[i] !== acc_w[i / 4][8*(i % 4) +: 8]) bad++;
      chk("R6 stream matches accepted words", 32'(bad), 32'd0);

      do_reset();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule